// File: doc/BRIEF.md
# I2C Slave Status Flag Unit

This block sits beside an I2C slave engine and keeps the peripheral's status flags. It watches the raw SCL and SDA lines through two-flop synchronizers and tracks bus activity from START and STOP conditions. After every START, including a repeated START, it shifts in the first byte on the bus. When the engine signals an address match, it loads the seven upper bits of that byte as the address code and the last bit as the transfer direction. For a 10-bit address the first byte is the header, so the code then holds the header pattern and the two upper address bits.

The block also samples an SMBus alert line for falling edges. It takes single-cycle event pulses from the rest of the peripheral for timeout, clock-low timeout, PEC mismatch, overrun/underrun and arbitration loss. Each error flag is sticky and has its own write-one-to-clear strobe. Driving the peripheral enable low clears the busy flag and every error flag. A PEC mismatch also produces a one-cycle NACK request for the engine. All flags are presented in one 32-bit read-only status word.

Top module: `i2cs_status_unit`

## Requirements
- R1: A START (SDA falling while SCL is high) sets busy, status bit 15. The bit reads 1 no later than 4 clock cycles after the SDA edge reaches the pins.
- R2: A STOP (SDA rising while SCL is high) clears busy within 4 cycles. Busy also clears at the first clock edge at which enable is 0.
- R3: After each START, SDA is sampled on the first 8 SCL rising edges, MSB first. An addr_hit pulse loads byte bits 7:1 into status bits 23:17 at the next edge. A 10-bit header 11110 + A9 A8 therefore reads as code 1111,0,A9,A8. A repeated START restarts the capture.
- R4: The same addr_hit loads status bit 16 from byte bit 0: 0 means write (slave receives) and 1 means read (slave transmits).
- R5: Alert, status bit 13, sets within 4 cycles of a falling edge on smba_n only when smb_host and alert_en are both 1. clr_alert clears it at the next edge.
- R6: Timeout, status bit 12, sets at the next edge on ev_timeout or ev_tlow. clr_timeout clears it.
- R7: PEC error, status bit 11, sets at the next edge on ev_pec_bad. In the same cycle, nack_req pulses high for exactly one cycle.
- R8: Overrun, status bit 10, sets on ev_ovr only when slave_mode and no_stretch are both 1. Otherwise ev_ovr has no effect. clr_ovr clears it.
- R9: Arbitration lost, status bit 9, sets at the next edge on ev_arlo. clr_arlo clears it.
- R10: While enable is 0, bits 15 and 13:9 are forced to 0, event pulses are ignored, and nack_req stays 0. The address code and direction keep their values.
- R11: When a set event and the clear strobe of the same flag arrive in the same cycle, the flag reads 1 afterwards.
- R12: Bits 31:24, 14 and 8:0 always read 0. With SMBUS_EN = 0, bits 13:11 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 clears busy and error flags |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| smba_n | input | 1 | Raw SMBus alert line, active low |
| smb_host | input | 1 | SMBus host configuration |
| alert_en | input | 1 | Alert detection enable |
| slave_mode | input | 1 | Peripheral is operating as slave |
| no_stretch | input | 1 | Clock stretching disabled |
| addr_hit | input | 1 | Address match pulse from the slave engine |
| ev_timeout | input | 1 | Timeout event pulse |
| ev_tlow | input | 1 | Extended clock-low timeout event pulse |
| ev_pec_bad | input | 1 | Received PEC mismatch pulse |
| ev_ovr | input | 1 | Overrun/underrun event pulse |
| ev_arlo | input | 1 | Arbitration loss event pulse |
| clr_alert | input | 1 | Clear strobe for alert |
| clr_timeout | input | 1 | Clear strobe for timeout |
| clr_pec | input | 1 | Clear strobe for PEC error |
| clr_ovr | input | 1 | Clear strobe for overrun |
| clr_arlo | input | 1 | Clear strobe for arbitration lost |
| status | output | 32 | Read-only status word |
| nack_req | output | 1 | One-cycle automatic NACK request |

## Verification
Event pulses, clear strobes, addr_hit and enable act at the first rising edge after they are driven. The bench drives them on a falling edge and compares status and nack_req on the next falling edge. SCL, SDA and the alert line pass through two synchronizer flops and one edge-detect register, so their effect lands on the third edge after a pin change. The bench therefore holds every pin level for four cycles before it moves a line again or samples a result. The random phase keeps the bus lines idle and applies one cycle of pulses per step, so its reference model advances exactly one edge per comparison.

// File: rtl/i2cs_status_unit.sv
module i2cs_status_unit #(
  parameter int SMBUS_EN = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        smba_n,
  input  logic        smb_host,
  input  logic        alert_en,
  input  logic        slave_mode,
  input  logic        no_stretch,
  input  logic        addr_hit,
  input  logic        ev_timeout,
  input  logic        ev_tlow,
  input  logic        ev_pec_bad,
  input  logic        ev_ovr,
  input  logic        ev_arlo,
  input  logic        clr_alert,
  input  logic        clr_timeout,
  input  logic        clr_pec,
  input  logic        clr_ovr,
  input  logic        clr_arlo,
  output logic [31:0] status,
  output logic        nack_req
);

  localparam logic SMB = (SMBUS_EN != 0);

  // synchronizers: [0] meta, [1] stable, [2] previous stable
  logic [2:0] scl_q, sda_q, smba_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q  <= 3'b111;
      sda_q  <= 3'b111;
      smba_q <= 3'b111;
    end else begin
      scl_q  <= {scl_q[1:0], scl_i};
      sda_q  <= {sda_q[1:0], sda_i};
      smba_q <= {smba_q[1:0], smba_n};
    end

  logic scl_hi, start_c, stop_c, scl_rise, smba_fall;
  assign scl_hi    = scl_q[1] & scl_q[2];
  assign start_c   = scl_hi & sda_q[2] & ~sda_q[1];
  assign stop_c    = scl_hi & ~sda_q[2] & sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign smba_fall = smba_q[2] & ~smba_q[1];

  // bus activity
  logic busy_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          busy_q <= 1'b0;
    else if (!enable)    busy_q <= 1'b0;
    else if (start_c)    busy_q <= 1'b1;
    else if (stop_c)     busy_q <= 1'b0;

  // first-byte capture after every START
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic       capturing;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg     <= 8'h00;
      bitcnt    <= 3'd0;
      capturing <= 1'b0;
    end else if (start_c) begin
      bitcnt    <= 3'd0;
      capturing <= 1'b1;
    end else if (capturing && scl_rise) begin
      shreg  <= {shreg[6:0], sda_q[1]};
      bitcnt <= bitcnt + 3'd1;
      if (bitcnt == 3'd7) capturing <= 1'b0;
    end

  logic [6:0] code_q;
  logic       dir_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_q <= 7'h00;
      dir_q  <= 1'b0;
    end else if (addr_hit) begin
      code_q <= shreg[7:1];
      dir_q  <= shreg[0];
    end

  // sticky error flags: set beats clear, enable low clears all
  logic set_alert, set_tmo, set_pec, set_ovr, set_arlo;
  assign set_alert = SMB & smb_host & alert_en & smba_fall;
  assign set_tmo   = SMB & (ev_timeout | ev_tlow);
  assign set_pec   = SMB & ev_pec_bad;
  assign set_ovr   = ev_ovr & slave_mode & no_stretch;
  assign set_arlo  = ev_arlo;

  logic alert_q, tmo_q, pec_q, ovr_q, arlo_q, nack_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alert_q <= 1'b0;
      tmo_q   <= 1'b0;
      pec_q   <= 1'b0;
      ovr_q   <= 1'b0;
      arlo_q  <= 1'b0;
      nack_q  <= 1'b0;
    end else if (!enable) begin
      alert_q <= 1'b0;
      tmo_q   <= 1'b0;
      pec_q   <= 1'b0;
      ovr_q   <= 1'b0;
      arlo_q  <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      alert_q <= set_alert | (alert_q & ~clr_alert);
      tmo_q   <= set_tmo   | (tmo_q   & ~clr_timeout);
      pec_q   <= set_pec   | (pec_q   & ~clr_pec);
      ovr_q   <= set_ovr   | (ovr_q   & ~clr_ovr);
      arlo_q  <= set_arlo  | (arlo_q  & ~clr_arlo);
      nack_q  <= ev_pec_bad;
    end

  assign nack_req = nack_q;
  assign status = {8'h00, code_q, dir_q, busy_q, 1'b0,
                   alert_q, tmo_q, pec_q, ovr_q, arlo_q, 9'h000};

  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enable && start_c |=> status[15]);
  assert_stop_clears_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && stop_c |=> !status[15]);
  assert_code_from_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> status[23:17] == $past(shreg[7:1]) && status[16] == $past(shreg[0]));
  assert_alert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(smb_host && alert_en) && !status[13] |=> !status[13]);
  assert_nack_on_pec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_pec_bad |=> nack_req);
  assert_ovr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(slave_mode && no_stretch) && !status[10] |=> !status[10]);
  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> status[15] == 1'b0 && status[13:9] == 5'b0 && !nack_req);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enable && ev_arlo && clr_arlo |=> status[9]);

endmodule

// File: tb/test_i2cs_status_unit.sv
module test_i2cs_status_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, scl, sda, smba, host, alen, slv, nostr, hit;
  logic e_tmo, e_tlow, e_pec, e_ovr, e_arlo;
  logic c_alert, c_tmo, c_pec, c_ovr, c_arlo;
  logic [31:0] st, st2;
  logic nack, nack2;

  i2cs_status_unit i_i2cs_status_unit (
    .clk(clk), .rst_n(rst_n), .enable(en), .scl_i(scl), .sda_i(sda), .smba_n(smba),
    .smb_host(host), .alert_en(alen), .slave_mode(slv), .no_stretch(nostr),
    .addr_hit(hit), .ev_timeout(e_tmo), .ev_tlow(e_tlow), .ev_pec_bad(e_pec),
    .ev_ovr(e_ovr), .ev_arlo(e_arlo), .clr_alert(c_alert), .clr_timeout(c_tmo),
    .clr_pec(c_pec), .clr_ovr(c_ovr), .clr_arlo(c_arlo), .status(st), .nack_req(nack));

  i2cs_status_unit #(.SMBUS_EN(0)) i_i2cs_status_unit_nosmb (
    .clk(clk), .rst_n(rst_n), .enable(en), .scl_i(scl), .sda_i(sda), .smba_n(smba),
    .smb_host(host), .alert_en(alen), .slave_mode(slv), .no_stretch(nostr),
    .addr_hit(hit), .ev_timeout(e_tmo), .ev_tlow(e_tlow), .ev_pec_bad(e_pec),
    .ev_ovr(e_ovr), .ev_arlo(e_arlo), .clr_alert(c_alert), .clr_timeout(c_tmo),
    .clr_pec(c_pec), .clr_ovr(c_ovr), .clr_arlo(c_arlo), .status(st2), .nack_req(nack2));

  int vectors = 0, bad = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_word(logic [7:0] b);
    return {8'h00, b[7:1], b[0], 16'h0000};
  endfunction

  task automatic quiet();
    {hit, e_tmo, e_tlow, e_pec, e_ovr, e_arlo} = '0;
    {c_alert, c_tmo, c_pec, c_ovr, c_arlo} = '0;
  endtask

  task automatic hold4();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus(logic c, logic d);
    scl = c; sda = d; hold4();
  endtask

  task automatic start_cond();   // from any state to SCL low after START
    bus(1'b0, sda); bus(1'b0, 1'b1); bus(1'b1, 1'b1); bus(1'b1, 1'b0); bus(1'b0, 1'b0);
  endtask

  task automatic stop_cond();
    bus(1'b0, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b1);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      bus(1'b0, b[k]); bus(1'b1, b[k]);
    end
    bus(1'b0, 1'b0);
  endtask

  task automatic pulse_hit();
    @(negedge clk); hit = 1'b1;
    @(negedge clk); hit = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  logic [4:0] ef;   // model of bits 13:9
  logic eb, enx;

  initial begin
    rst_n = 0; en = 1; scl = 1; sda = 1; smba = 1; host = 0; alen = 0; slv = 1; nostr = 1;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset word", st, 32'h0);
    chk("R7 reset nack", {31'h0, nack}, 32'h0);

    // R1 / R3 / R4: 7-bit write to 0x5A
    start_cond();
    chk("R1 busy after START", {31'h0, st[15]}, 32'h1);
    send_byte(8'hB4);
    pulse_hit();
    chk("R3 code 0x5A", st & 32'h00FF_0000, addr_word(8'hB4));
    chk("R4 write dir", {31'h0, st[16]}, 32'h0);
    stop_cond();
    chk("R2 busy cleared by STOP", {31'h0, st[15]}, 32'h0);

    // 7-bit read from 0x23
    start_cond(); send_byte(8'h47); pulse_hit();
    chk("R4 read dir/code", st & 32'h00FF_0000, addr_word(8'h47));

    // 10-bit: header write then repeated START with header read
    stop_cond(); start_cond(); send_byte(8'hF4); pulse_hit();
    chk("R3 10-bit header write", st & 32'h00FF_0000, addr_word(8'hF4));
    start_cond();
    chk("R1 busy on repeated START", {31'h0, st[15]}, 32'h1);
    send_byte(8'hF5); pulse_hit();
    chk("R3 repeated START recapture", st[23:16], 8'hF5);

    // R10: enable low clears busy, holds code
    @(negedge clk); e_arlo = 1; e_pec = 1;
    @(negedge clk); quiet(); en = 0;
    @(negedge clk);
    chk("R10 flags cleared, code held", st, addr_word(8'hF5));
    e_arlo = 1; e_tmo = 1;
    @(negedge clk); quiet();
    chk("R10 events ignored when disabled", st[15:9], 7'h0);
    chk("R10 nack quiet", {31'h0, nack}, 32'h0);
    en = 1; stop_cond();

    // R7
    @(negedge clk); e_pec = 1;
    @(negedge clk); e_pec = 0;
    chk("R7 pec flag", {31'h0, st[11]}, 32'h1);
    chk("R7 nack pulse", {31'h0, nack}, 32'h1);
    @(negedge clk);
    chk("R7 nack one cycle", {31'h0, nack}, 32'h0);
    c_pec = 1; @(negedge clk); c_pec = 0;
    chk("R7 pec cleared", {31'h0, st[11]}, 32'h0);

    // R6
    e_tlow = 1; @(negedge clk); e_tlow = 0;
    chk("R6 tlow sets timeout", {31'h0, st[12]}, 32'h1);
    c_tmo = 1; @(negedge clk); c_tmo = 0;
    chk("R6 timeout cleared", {31'h0, st[12]}, 32'h0);

    // R8
    slv = 0; e_ovr = 1; @(negedge clk); e_ovr = 0;
    chk("R8 ovr ignored when not slave", {31'h0, st[10]}, 32'h0);
    slv = 1; nostr = 0; e_ovr = 1; @(negedge clk); e_ovr = 0;
    chk("R8 ovr ignored with stretching", {31'h0, st[10]}, 32'h0);
    nostr = 1; e_ovr = 1; @(negedge clk); e_ovr = 0;
    chk("R8 ovr sets", {31'h0, st[10]}, 32'h1);
    c_ovr = 1; @(negedge clk); c_ovr = 0;

    // R9 / R11
    e_arlo = 1; c_arlo = 1; @(negedge clk); quiet();
    chk("R11 set beats clear", {31'h0, st[9]}, 32'h1);
    c_arlo = 1; @(negedge clk); c_arlo = 0;
    chk("R9 arlo cleared", {31'h0, st[9]}, 32'h0);

    // R5 alert
    smba = 0; hold4();
    chk("R5 alert ignored when host off", {31'h0, st[13]}, 32'h0);
    smba = 1; host = 1; alen = 1; hold4();
    smba = 0; hold4();
    chk("R5 alert set", {31'h0, st[13]}, 32'h1);
    chk("R12 no alert when SMBus absent", {29'h0, st2[13:11]}, 32'h0);
    c_alert = 1; @(negedge clk); c_alert = 0;
    chk("R5 alert cleared", {31'h0, st[13]}, 32'h0);
    smba = 1; hold4();

    // random phase with a bench model of bits 15 and 13:9
    void'($urandom(32'd2024));
    ef = st[13:9]; eb = st[15];
    for (int i = 0; i < 400; i++) begin
      enx = ($urandom % 12) != 0;
      en = enx;
      host = $urandom % 2; alen = $urandom % 2; slv = $urandom % 2; nostr = $urandom % 2;
      e_tmo = ($urandom % 5) == 0; e_tlow = ($urandom % 7) == 0; e_pec = ($urandom % 5) == 0;
      e_ovr = ($urandom % 3) == 0; e_arlo = ($urandom % 5) == 0;
      c_alert = $urandom % 2; c_tmo = ($urandom % 3) == 0; c_pec = ($urandom % 3) == 0;
      c_ovr = ($urandom % 3) == 0; c_arlo = ($urandom % 3) == 0;
      if (!enx) begin ef = '0; eb = 0; end
      else begin
        ef[4] = ef[4] & ~c_alert;
        ef[3] = (e_tmo | e_tlow) | (ef[3] & ~c_tmo);
        ef[2] = e_pec | (ef[2] & ~c_pec);
        ef[1] = (e_ovr & slv & nostr) | (ef[1] & ~c_ovr);
        ef[0] = e_arlo | (ef[0] & ~c_arlo);
      end
      @(negedge clk);
      chk("R6 R8 R9 R10 R11 random flags", {26'h0, st[15], st[13:9]}, {26'h0, eb, ef});
      chk("R7 R10 random nack", {31'h0, nack}, {31'h0, enx & e_pec});
      chk("R12 reserved and SMBus-off bits", st2 & 32'hFF00_7FFF, {18'h0, ef[1:0], 9'h0} & 32'h0000_0600);
    end
    quiet(); en = 1;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule